// File: doc/BRIEF.md
# Crossbar Clock Generator Bank

This block drives a set of output clocks, each built from one of several free-running reference clocks. For each channel a crossbar selector picks the reference. A gate and a wide pre-divider follow, then a narrow final divider. A final gate sits on the divider's output. Software programs every channel through a word-addressed register port, and each register reads back what it holds.

The whole datapath is clocked by a fast system clock that oversamples the reference inputs. Each divider counts both edges of its input level, so any integer ratio gives an output that is high for exactly half its period whenever its input is balanced. Gates switch only while the signal they gate is low. New ratios and new selections take effect only at a divider period boundary, so no shortened pulse reaches an output.

Large total ratios are meant to use the pre-divider with the final divider at one. Ratios of 64 or less use the final divider alone, which keeps the duty cycle clean.

Top module: `ckx_top`

## Requirements
- R1: After reset every register reads zero and every `clkOut` bit stays low while the references run.
- R2: Selection settings share 32-bit words at byte address 0x18 + 4·(i div 4), with channel i in byte lane (i mod 4). Within that lane, bits [5:0] hold the reference select and bit 6 holds the pre-divider gate. Bit 7 of every lane, and lanes that belong to no channel, read back zero and ignore writes.
- R3: The pre-divider ratio field of channel i is bits [9:0] of the word at 0x58 + 4·i, and bits [31:10] read zero.
- R4: The final-divider word of channel i sits at 0x164 + 4·i. Bits [5:0] hold the ratio field and bit 6 gates the channel output. Bits [31:7] read zero.
- R5: A ratio field value N divides by N+1, so a zero field in both dividers reproduces the reference period.
- R6: The output period equals the reference period × (pre field + 1) × (final field + 1), and the output is high for exactly half of it.
- R7: Clearing the final gate holds the channel output low. It leaves the pre-divider gate and the other fields unchanged, and setting the gate again restores the programmed period.
- R8: Clearing the pre-divider gate stops the channel output from toggling.
- R9: A select value at or above the number of references picks a constant low level, so the output stops toggling.
- R10: A ratio change during operation yields only high pulses of the old or the new width, with none in between.
- R11: A reference select change during operation yields only high pulses of the old or the new width.
- R12: Addresses that hold no register read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the references |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address of the register word |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational readback of the addressed word |
| refIn | input | NUM_REF | Reference clock levels |
| clkOut | output | NUM_OUT | Generated channel clocks |

## Verification
The bench builds the block with five channels and four references. Five channels leave the second selection word with only one live lane, so the ignored lanes and a missing third word can be checked. Four references leave selects 4 to 63 out of range. The reference half periods are 2, 3, 5 and 7 system cycles, which makes each reference period distinct and lets the series ratios be told apart. A pre-divider ratio of 100 reaches deep into the wide field within a short run.

// File: rtl/ckx_pkg.sv
package ckx_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SEL_W     = 6;
  localparam int PDIV_W    = 10;
  localparam int FDIV_W    = 6;
  localparam int LANE_W    = 8;
  localparam int LANES     = 4;
  localparam int GATE_BIT  = 6;
  localparam int XBAR_BASE = 'h18;
  localparam int PDIV_BASE = 'h58;
  localparam int FDIV_BASE = 'h164;

  // Per-channel settings handed from control to datapath
  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic              preEn;
    logic [PDIV_W-1:0] preDiv;
    logic              finEn;
    logic [FDIV_W-1:0] finDiv;
  } chCfg_t;
endpackage

// File: rtl/ckx_regs.sv
module ckx_regs
  import ckx_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output chCfg_t            cfg [NUM_OUT]
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int XWORDS = (NUM_OUT + LANES - 1) / LANES;

  chCfg_t cfgQ [NUM_OUT];
  logic   unusedWdata;
  assign unusedWdata = &{1'b0, regWdata};

  function automatic logic [ADDR_W-1:0] xAddr(input int i);
    return ADDR_W'(XBAR_BASE + 4 * (i / LANES));
  endfunction
  function automatic logic [ADDR_W-1:0] pAddr(input int i);
    return ADDR_W'(PDIV_BASE + 4 * i);
  endfunction
  function automatic logic [ADDR_W-1:0] fAddr(input int i);
    return ADDR_W'(FDIV_BASE + 4 * i);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_OUT; i++) cfgQ[i] <= '0;
    end else if (regWe) begin
      for (int i = 0; i < NUM_OUT; i++) begin
        if (regAddr == xAddr(i)) begin
          cfgQ[i].sel   <= regWdata[LANE_W*(i%LANES) +: SEL_W];
          cfgQ[i].preEn <= regWdata[LANE_W*(i%LANES) + GATE_BIT];
        end
        if (regAddr == pAddr(i)) cfgQ[i].preDiv <= regWdata[PDIV_W-1:0];
        if (regAddr == fAddr(i)) begin
          cfgQ[i].finDiv <= regWdata[FDIV_W-1:0];
          cfgQ[i].finEn  <= regWdata[GATE_BIT];
        end
      end
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_OUT; i++) begin
      if (regAddr == xAddr(i))
        regRdata[LANE_W*(i%LANES) +: LANE_W] = LANE_W'({cfgQ[i].preEn, cfgQ[i].sel});
      if (regAddr == pAddr(i)) regRdata = 32'(cfgQ[i].preDiv);
      if (regAddr == fAddr(i)) regRdata = 32'({cfgQ[i].finEn, cfgQ[i].finDiv});
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_OUT; i++) cfg[i] = cfgQ[i];
  end

  generate
    for (genvar w = 0; w < XWORDS; w++) begin : g_xchk
      p_lane_top_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
        (regAddr == ADDR_W'(XBAR_BASE + 4*w)) |-> ((regRdata & 32'h8080_8080) == 32'h0));
    end
    for (genvar c = 0; c < NUM_OUT; c++) begin : g_dchk
      p_pdiv_hi_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
        (regAddr == ADDR_W'(PDIV_BASE + 4*c)) |-> (regRdata[31:PDIV_W] == '0));
      p_fdiv_hi_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
        (regAddr == ADDR_W'(FDIV_BASE + 4*c)) |-> (regRdata[31:GATE_BIT+1] == '0));
    end
  endgenerate
endmodule

// File: rtl/ckx_divstage.sv
module ckx_divstage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inLvl,
  input  logic [W-1:0] ratio,
  output logic         outLvl,
  output logic         atBoundary
);
  timeunit 1ns;
  timeprecision 1ps;

  logic         inPrev;
  logic [W:0]   cnt, cntNext, topCnt, highLim;
  logic [W-1:0] ratioAct;

  // Period spans 2*(ratio+1) input edges; high for the first ratio+1 of them
  assign topCnt     = {ratioAct, 1'b1};
  assign highLim    = (W+1)'(ratioAct) + (W+1)'(1);
  assign atBoundary = (cnt == '0);

  always_comb begin
    cntNext = cnt;
    if (cnt == '0) begin
      if (inLvl && !inPrev) cntNext = (W+1)'(1);
    end else if (inLvl != inPrev) begin
      cntNext = (cnt == topCnt) ? '0 : cnt + (W+1)'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPrev   <= 1'b0;
      cnt      <= '0;
      ratioAct <= '0;
      outLvl   <= 1'b0;
    end else begin
      inPrev <= inLvl;
      cnt    <= cntNext;
      if (cnt == '0) ratioAct <= ratio;
      outLvl <= (cntNext != '0) && (cntNext <= highLim);
    end
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= topCnt);
  p_ratio_swap_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ratioAct) |-> ($past(cnt) == '0));
endmodule

// File: rtl/ckx_chan.sv
module ckx_chan
  import ckx_pkg::*;
#(
  parameter int NUM_REF = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] refIn,
  input  chCfg_t             cfg,
  output logic               clkOut
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [SEL_W-1:0] selAct;
  logic muxOut, newSrc, preAct, finAct;
  logic pOut, pBoundary, fOut, fBoundary;

  always_comb begin
    muxOut = 1'b0;
    newSrc = 1'b0;
    for (int r = 0; r < NUM_REF; r++) begin
      if (selAct  == SEL_W'(r)) muxOut = refIn[r];
      if (cfg.sel == SEL_W'(r)) newSrc = refIn[r];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selAct <= '0;
      preAct <= 1'b0;
      finAct <= 1'b0;
    end else begin
      if (pBoundary && !muxOut && !newSrc) selAct <= cfg.sel;
      if (!muxOut) preAct <= cfg.preEn;
      if (!fOut)   finAct <= cfg.finEn;
    end
  end

  ckx_divstage #(.W(PDIV_W)) u_pre (
    .clk(clk), .rstN(rstN), .inLvl(muxOut & preAct), .ratio(cfg.preDiv),
    .outLvl(pOut), .atBoundary(pBoundary)
  );

  ckx_divstage #(.W(FDIV_W)) u_fin (
    .clk(clk), .rstN(rstN), .inLvl(pOut), .ratio(cfg.finDiv),
    .outLvl(fOut), .atBoundary(fBoundary)
  );

  logic unusedBoundary;
  assign unusedBoundary = fBoundary;

  assign clkOut = fOut & finAct;

  p_sel_swap_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(selAct) |-> !$past(muxOut));
  p_pregate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(preAct) |-> !$past(muxOut));
  p_fingate_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(finAct) |-> !$past(fOut));
  p_unsel_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (32'(selAct) >= NUM_REF) |-> !muxOut);
endmodule

// File: rtl/ckx_datapath.sv
module ckx_datapath
  import ckx_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int NUM_REF = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] refIn,
  input  chCfg_t             cfg [NUM_OUT],
  output logic [NUM_OUT-1:0] clkOut
);
  timeunit 1ns;
  timeprecision 1ps;

  generate
    for (genvar c = 0; c < NUM_OUT; c++) begin : g_ch
      ckx_chan #(.NUM_REF(NUM_REF)) u_ch (
        .clk(clk), .rstN(rstN), .refIn(refIn), .cfg(cfg[c]), .clkOut(clkOut[c])
      );
    end
  endgenerate
endmodule

// File: rtl/ckx_top.sv
module ckx_top
  import ckx_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int NUM_REF = 8,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [31:0]        regWdata,
  output logic [31:0]        regRdata,
  input  logic [NUM_REF-1:0] refIn,
  output logic [NUM_OUT-1:0] clkOut
);
  timeunit 1ns;
  timeprecision 1ps;

  chCfg_t cfg [NUM_OUT];

  ckx_regs #(.NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .cfg(cfg)
  );

  ckx_datapath #(.NUM_OUT(NUM_OUT), .NUM_REF(NUM_REF)) u_dp (
    .clk(clk), .rstN(rstN), .refIn(refIn), .cfg(cfg), .clkOut(clkOut)
  );
endmodule

// File: tb/test_ckx_top.sv
module test_ckx_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NO = 5;
  localparam int NR = 4;
  localparam int AW = 12;

  logic clk = 1'b0, rstN = 1'b0, regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  wire  [31:0] regRdata;
  wire  [NO-1:0] clkOut;
  logic r0 = 1'b0, r1 = 1'b0, r2 = 1'b0, r3 = 1'b0;
  wire  [NR-1:0] refIn = {r3, r2, r1, r0};

  int nChecks = 0, nFail = 0;
  logic [31:0] mX [2];
  logic [31:0] mP [NO];
  logic [31:0] mF [NO];

  ckx_top #(.NUM_OUT(NO), .NUM_REF(NR), .ADDR_W(AW)) i_ckx_top (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .refIn(refIn), .clkOut(clkOut)
  );

  always #2.5 clk = ~clk;

  // References: half periods of 2, 3, 5, 7 system cycles
  initial forever begin repeat (2) @(negedge clk); r0 = ~r0; end
  initial forever begin repeat (3) @(negedge clk); r1 = ~r1; end
  initial forever begin repeat (5) @(negedge clk); r2 = ~r2; end
  initial forever begin repeat (7) @(negedge clk); r3 = ~r3; end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  endtask

  function automatic logic [31:0] expRd(input logic [AW-1:0] a);
    if (a == AW'('h18)) return mX[0];
    if (a == AW'('h1C)) return mX[1];
    for (int i = 0; i < NO; i++) begin
      if (a == AW'('h58 + 4*i))  return mP[i];
      if (a == AW'('h164 + 4*i)) return mF[i];
    end
    return 32'h0;
  endfunction

  task automatic regWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(posedge clk);
    if (a == AW'('h18)) mX[0] = d & 32'h7F7F_7F7F;
    if (a == AW'('h1C)) mX[1] = d & 32'h0000_007F;
    for (int i = 0; i < NO; i++) begin
      if (a == AW'('h58 + 4*i))  mP[i] = d & 32'h3FF;
      if (a == AW'('h164 + 4*i)) mF[i] = d & 32'h7F;
    end
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic regRead(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    @(posedge clk); #2;
    check(regRdata == exp, tag, regRdata, exp);
  endtask

  // Register model compared on every clock
  initial forever begin
    @(posedge clk); #2;
    if (rstN) check(regRdata == expRd(regAddr), "R2 R3 R4 R12 readback model", regRdata, expRd(regAddr));
  end

  task automatic measure(input int ch, input int expPer, input string tag);
    logic p, c;
    int per, hi;
    bit found;
    repeat (3*expPer + 40) @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      found = 0;
      @(posedge clk); #2; p = clkOut[ch];
      for (int g = 0; g < 5000; g++) begin
        @(posedge clk); #2; c = clkOut[ch];
        if (c && !p) begin found = 1; break; end
        p = c;
      end
    end
    p = 1'b1; per = 1; hi = 1;
    for (int g = 0; g < 5000; g++) begin
      @(posedge clk); #2; c = clkOut[ch];
      if (c && !p) break;
      per++;
      if (c) hi++;
      p = c;
    end
    check(found && per == expPer, {tag, " period"}, per, expPer);
    check(found && hi == expPer/2, {tag, " high time"}, hi, expPer/2);
  endtask

  task automatic noToggle(input int ch, input int cycles, input bit mustBeLow, input string tag);
    logic p, c;
    int edges, highs;
    edges = 0; highs = 0;
    @(posedge clk); #2; p = clkOut[ch];
    for (int g = 0; g < cycles; g++) begin
      @(posedge clk); #2; c = clkOut[ch];
      if (c != p) edges++;
      if (c) highs++;
      p = c;
    end
    check(edges == 0, {tag, " edges"}, edges, 0);
    if (mustBeLow) check(highs == 0, {tag, " high samples"}, highs, 0);
  endtask

  task automatic widths(input int ch, input int wa, input int wb, input int cycles, input string tag);
    logic p, c;
    int w, n, bad, lastBad;
    bit inPulse;
    w = 0; n = 0; bad = 0; lastBad = 0; inPulse = 0;
    @(posedge clk); #2; p = clkOut[ch];
    for (int g = 0; g < cycles; g++) begin
      @(posedge clk); #2; c = clkOut[ch];
      if (c && !p) begin inPulse = 1; w = 1; end
      else if (c && inPulse) w++;
      else if (!c && p && inPulse) begin
        n++;
        if (w != wa && w != wb) begin bad++; lastBad = w; end
      end
      p = c;
    end
    check(bad == 0 && n > 2, {tag, " pulse width"}, lastBad, wa);
  endtask

  initial begin
    repeat (1_900_00) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    mX[0] = 0; mX[1] = 0;
    for (int i = 0; i < NO; i++) begin mP[i] = 0; mF[i] = 0; end
    repeat (5) @(negedge clk);
    check(clkOut == '0, "R1 outputs in reset", clkOut, 0);
    rstN = 1'b1;
    regRead(AW'('h18), 32'h0, "R1 select word reset");
    regRead(AW'('h60), 32'h0, "R1 pre-divider reset");
    regRead(AW'('h170), 32'h0, "R1 final-divider reset");
    noToggle(1, 60, 1'b1, "R1 idle output");

    // R2: channels 0..3 select refs 0..3 with pre gate; bit 7 written but dropped
    regWrite(AW'('h18), 32'hC3C2_C1C0);
    regRead(AW'('h18), 32'h4342_4140, "R2 packed lanes");
    regWrite(AW'('h1C), 32'hFFFF_FFC1);
    regRead(AW'('h1C), 32'h0000_0041, "R2 absent lanes");
    // R3 pre-divider fields
    regWrite(AW'('h58), 32'h0);
    regWrite(AW'('h5C), 32'h0);
    regWrite(AW'('h60), 32'hFFFF_FC03);
    regRead(AW'('h60), 32'h3, "R3 upper bits");
    regWrite(AW'('h64), 32'h1);
    regWrite(AW'('h68), 32'd99);
    // R4 final-divider fields
    regWrite(AW'('h164), 32'h40);
    regWrite(AW'('h168), 32'h42);
    regWrite(AW'('h16C), 32'h40);
    regWrite(AW'('h170), 32'h41);
    regWrite(AW'('h174), 32'hFFFF_FFC0);
    regRead(AW'('h174), 32'h40, "R4 upper bits");
    // R12 unmapped addresses
    regWrite(AW'('h100), 32'hFFFF_FFFF);
    regRead(AW'('h100), 32'h0, "R12 unmapped word");
    regRead(AW'('h20), 32'h0, "R12 missing select word");

    measure(0, 4,   "R5 pass-through");
    measure(1, 18,  "R5 final ratio 3");
    measure(2, 40,  "R6 pre ratio 4");
    measure(3, 56,  "R6 series 2x2");
    measure(4, 600, "R6 pre ratio 100");

    // R7 final gate off, pre gate untouched
    regWrite(AW'('h168), 32'h02);
    repeat (60) @(posedge clk);
    noToggle(1, 300, 1'b1, "R7 disabled output");
    regRead(AW'('h18), 32'h4342_4140, "R7 pre gate kept");
    regWrite(AW'('h168), 32'h42);
    measure(1, 18, "R7 re-enabled");

    // R10 final ratio change 3 -> 1
    fork
      widths(1, 9, 3, 300, "R10 final change");
      begin repeat (60) @(negedge clk); regWrite(AW'('h168), 32'h40); end
    join
    measure(1, 6, "R10 final new period");

    // R10 pre ratio change 4 -> 2
    fork
      widths(2, 20, 10, 400, "R10 pre change");
      begin repeat (100) @(negedge clk); regWrite(AW'('h60), 32'h1); end
    join
    measure(2, 20, "R10 pre new period");

    // R11 channel 2 moves from ref2 to ref1
    fork
      widths(2, 10, 6, 400, "R11 select change");
      begin repeat (100) @(negedge clk); regWrite(AW'('h18), 32'h4341_4140); end
    join
    measure(2, 12, "R11 new period");

    // R8 pre gate off on channel 0
    regWrite(AW'('h18), 32'h4341_4100);
    repeat (50) @(posedge clk);
    noToggle(0, 300, 1'b0, "R8 pre gate off");

    // R9 out-of-range select on channel 4
    regWrite(AW'('h1C), 32'h45);
    repeat (1300) @(posedge clk);
    noToggle(4, 700, 1'b1, "R9 unselected reference");

    finishRun();
  end
endmodule